// File: doc/BRIEF.md
# Lite Serial Controller with Register Bus

This block connects a 32-bit, word-addressed register bus to one asynchronous serial line pair. Software writes characters into a sixteen-entry transmit queue and reads them back from a sixteen-entry receive queue. A fixed-format serializer and deserializer, driven by a shared divider, move the characters on and off the wire. The character format is set when the block is built: 5 to 8 data bits, no, even or odd parity, and one stop bit. The same build-time settings fix the line rate. The rate is `CLKS_PER_TICK` clocks per oversample tick, with sixteen ticks per bit.

The bus has four word slots. Slot 0 reads and pops received characters. Slot 1 accepts characters to send. Slot 2 reports status. Slot 3 takes control writes, which clear either queue and switch the single interrupt output on or off. The interrupt output is a one-cycle pulse meant to be caught on its rising edge. Received characters with line errors are still stored, and the error is latched in the status word until software reads that word.

Top module: `serial_lite_ctrl`

## Requirements
- R1: After reset the status word (slot 2) reads 0x04, the interrupt output is low and the transmit line idles high.
- R2: The receiver detects a start bit, confirms it at half a bit time, then samples each following bit at mid-bit (sixteen ticks apart). Data bits arrive least significant first. A valid character sets status bit 0 (receive data valid).
- R3: Each written character goes out as one low start bit, the data bits least significant first, the parity bit when enabled (even parity makes the total count of ones even), and one high stop bit. Between characters the line is high.
- R4: Each queue holds 16 characters. Status bit 1 is set while the receive queue is full, bit 2 while the transmit queue is empty and bit 3 while the transmit queue is full.
- R5: Reading slot 0 returns the oldest received character in bits 7:0 and removes it. When the receive queue is empty, a read of slot 0 returns 0 and changes nothing.
- R6: A write to slot 1 takes bits 7:0 as the character. When the transmit queue is full, the write is ignored and the character is never sent.
- R7: If a character completes while the receive queue is full, it is dropped and status bit 5 (overrun) is set.
- R8: A low stop-bit sample sets status bit 6 (framing). A parity mismatch sets status bit 7 (parity). In both cases the character is still stored. Bits 5, 6 and 7 clear after a read of the status word.
- R9: A control write with bit 0 set empties the transmit queue, so status bit 2 then reads 1 and only a character already on the line is finished. A control write with bit 1 set empties the receive queue.
- R10: Control bit 4 enables the interrupt and is reflected in status bit 4. A control write with bit 4 clear disables it. While it is enabled, the interrupt output pulses for one cycle when the receive queue becomes non-empty or the transmit queue becomes empty. While it is disabled, the output never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word slot: 0 receive, 1 transmit, 2 status, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access; a slot 0 read pops at the clock edge |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| rx_line | input | 1 | Serial input, asynchronous to clk |
| tx_line | output | 1 | Serial output, idle high |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The receiver is driven with 128 distinct byte values from an odd-stride walk. The transmitter is checked against 64 values decoded independently at mid-bit. This separates bit-order, parity-polarity and bit-count faults. Frames with a flipped parity bit are sent to isolate each error flag and to confirm that status reads clear those flags. The same applies to frames with a shortened low stop bit, which also exercise rejection of a false start.

Filling each queue to exactly sixteen characters and then offering one more separates the depth and full-flag behaviour from overrun and dropped writes. The empty-read, queue-clear and interrupt-enabled and disabled sequences show which events may and may not disturb state or pulse the interrupt.

// File: rtl/serial_lite_pkg.sv
`timescale 1ns/1ps
package serial_lite_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } parity_e;

  typedef enum logic [2:0] {
    FR_IDLE   = 3'd0,
    FR_START  = 3'd1,
    FR_DATA   = 3'd2,
    FR_PARITY = 3'd3,
    FR_STOP   = 3'd4
  } frame_st_e;

  localparam logic [1:0] SLOT_RXDATA  = 2'd0;
  localparam logic [1:0] SLOT_TXDATA  = 2'd1;
  localparam logic [1:0] SLOT_STATUS  = 2'd2;
  localparam logic [1:0] SLOT_CONTROL = 2'd3;

  // Parity bit to append after the low nbits of d.
  function automatic logic parity_of(input logic [7:0] d, input int unsigned nbits,
                                     input parity_e mode);
    logic p;
    p = 1'b0;
    for (int unsigned i = 0; i < 8; i++) begin
      if (i < nbits) p = p ^ d[i];
    end
    return (mode == PAR_ODD) ? ~p : p;
  endfunction

endpackage

// File: rtl/sl_fifo.sv
`timescale 1ns/1ps
module sl_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];
  assign count   = cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = bump(wr_q);
      if (do_pop)  rd_n = bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + CW'(1);
        2'b01:   cnt_n = cnt_q - CW'(1);
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q] <= din;
  end

endmodule

// File: rtl/sl_tx_engine.sv
`timescale 1ns/1ps
module sl_tx_engine
  import serial_lite_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter parity_e     PARITY    = PAR_EVEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       avail,
  input  logic [7:0] din,
  output logic       take,
  output logic       line,
  output logic       busy
);

  localparam logic [2:0] LAST_IDX = 3'(DATA_BITS - 1);
  localparam bit         HAS_PAR  = (PARITY != PAR_NONE);

  frame_st_e  st_q, st_n;
  logic [3:0] tk_q, tk_n;
  logic [2:0] idx_q, idx_n;
  logic [7:0] sh_q, sh_n;
  logic       par_q, par_n;

  always_comb begin
    st_n  = st_q;
    tk_n  = tk_q;
    idx_n = idx_q;
    sh_n  = sh_q;
    par_n = par_q;
    take  = 1'b0;
    if (st_q == FR_IDLE) begin
      if (avail) begin
        take  = 1'b1;
        sh_n  = din;
        par_n = parity_of(din, DATA_BITS, PARITY);
        tk_n  = '0;
        idx_n = '0;
        st_n  = FR_START;
      end
    end else if (tick) begin
      tk_n = tk_q + 4'd1;
      if (tk_q == 4'd15) begin
        case (st_q)
          FR_START: st_n = FR_DATA;
          FR_DATA: begin
            sh_n  = sh_q >> 1;
            idx_n = idx_q + 3'd1;
            if (idx_q == LAST_IDX) st_n = HAS_PAR ? FR_PARITY : FR_STOP;
          end
          FR_PARITY: st_n = FR_STOP;
          default:   st_n = FR_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st_q)
      FR_START:  line = 1'b0;
      FR_DATA:   line = sh_q[0];
      FR_PARITY: line = par_q;
      default:   line = 1'b1;
    endcase
  end

  assign busy = (st_q != FR_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_IDLE;
      tk_q  <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      tk_q  <= tk_n;
      idx_q <= idx_n;
      sh_q  <= sh_n;
      par_q <= par_n;
    end
  end

endmodule

// File: rtl/sl_rx_engine.sv
`timescale 1ns/1ps
module sl_rx_engine
  import serial_lite_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter parity_e     PARITY    = PAR_EVEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_async,
  output logic       done,
  output logic [7:0] data,
  output logic       frame_err,
  output logic       par_err
);

  localparam logic [2:0] LAST_IDX = 3'(DATA_BITS - 1);
  localparam bit         HAS_PAR  = (PARITY != PAR_NONE);

  logic       s1_q, line_q;
  frame_st_e  st_q, st_n;
  logic [3:0] tk_q, tk_n;
  logic [2:0] idx_q, idx_n;
  logic [7:0] sh_q, sh_n;
  logic       bad_q, bad_n;
  logic       done_q, done_n;
  logic [7:0] data_q, data_n;
  logic       fe_q, fe_n, pe_q, pe_n;

  always_comb begin
    st_n   = st_q;
    tk_n   = tk_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    bad_n  = bad_q;
    done_n = 1'b0;
    data_n = data_q;
    fe_n   = fe_q;
    pe_n   = pe_q;
    if (tick) begin
      case (st_q)
        FR_IDLE: begin
          if (!line_q) begin
            st_n = FR_START;
            tk_n = '0;
          end
        end
        FR_START: begin
          if (tk_q == 4'd7) begin
            tk_n = '0;
            if (!line_q) begin
              st_n  = FR_DATA;
              idx_n = '0;
              sh_n  = '0;
              bad_n = 1'b0;
            end else begin
              st_n = FR_IDLE;
            end
          end else begin
            tk_n = tk_q + 4'd1;
          end
        end
        FR_DATA: begin
          tk_n = tk_q + 4'd1;
          if (tk_q == 4'd15) begin
            sh_n[idx_q] = line_q;
            idx_n = idx_q + 3'd1;
            if (idx_q == LAST_IDX) st_n = HAS_PAR ? FR_PARITY : FR_STOP;
          end
        end
        FR_PARITY: begin
          tk_n = tk_q + 4'd1;
          if (tk_q == 4'd15) begin
            bad_n = (line_q != parity_of(sh_q, DATA_BITS, PARITY));
            st_n  = FR_STOP;
          end
        end
        default: begin
          tk_n = tk_q + 4'd1;
          if (tk_q == 4'd15) begin
            done_n = 1'b1;
            data_n = sh_q;
            fe_n   = !line_q;
            pe_n   = HAS_PAR && bad_q;
            st_n   = FR_IDLE;
          end
        end
      endcase
    end
  end

  assign done      = done_q;
  assign data      = data_q;
  assign frame_err = fe_q;
  assign par_err   = pe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      line_q <= 1'b1;
      st_q   <= FR_IDLE;
      tk_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      bad_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      s1_q   <= rx_async;
      line_q <= s1_q;
      st_q   <= st_n;
      tk_q   <= tk_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      bad_q  <= bad_n;
      done_q <= done_n;
      data_q <= data_n;
      fe_q   <= fe_n;
      pe_q   <= pe_n;
    end
  end

endmodule

// File: rtl/serial_lite_ctrl.sv
`timescale 1ns/1ps
module serial_lite_ctrl
  import serial_lite_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 4,
  parameter int unsigned DATA_BITS     = 8,
  parameter parity_e     PARITY        = PAR_EVEN,
  parameter int unsigned FIFO_DEPTH    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic        rx_line,
  output logic        tx_line,
  output logic        irq
);

  localparam int unsigned CW   = $clog2(FIFO_DEPTH) + 1;
  localparam int unsigned DIVW = $clog2(CLKS_PER_TICK) + 1;
  localparam logic [7:0]  CHAR_MASK = 8'((16'd1 << DATA_BITS) - 16'd1);

  // oversample tick divider
  logic [DIVW-1:0] div_q, div_n;
  logic            tick;
  assign tick  = (div_q == DIVW'(CLKS_PER_TICK - 1));
  assign div_n = tick ? '0 : div_q + DIVW'(1);

  // bus decode
  logic wr_tx, wr_ctl, rd_rx, rd_stat;
  assign wr_tx   = bus_wr && (bus_addr == SLOT_TXDATA);
  assign wr_ctl  = bus_wr && (bus_addr == SLOT_CONTROL);
  assign rd_rx   = bus_rd && (bus_addr == SLOT_RXDATA);
  assign rd_stat = bus_rd && (bus_addr == SLOT_STATUS);

  // transmit path
  logic [7:0]    tx_dout;
  logic [CW-1:0] tx_count;
  logic          tx_empty, tx_full, tx_take, tx_busy;

  sl_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(wr_ctl && bus_wdata[0]),
    .push(wr_tx), .din(bus_wdata[7:0] & CHAR_MASK), .pop(tx_take),
    .dout(tx_dout), .count(tx_count), .empty(tx_empty), .full(tx_full)
  );

  sl_tx_engine #(.DATA_BITS(DATA_BITS), .PARITY(PARITY)) tx_eng_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .avail(!tx_empty), .din(tx_dout),
    .take(tx_take), .line(tx_line), .busy(tx_busy)
  );

  // receive path
  logic [7:0]    rx_char, rx_dout;
  logic [CW-1:0] rx_count;
  logic          rx_done, rx_fe, rx_pe, rx_empty, rx_full;

  sl_rx_engine #(.DATA_BITS(DATA_BITS), .PARITY(PARITY)) rx_eng_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_async(rx_line),
    .done(rx_done), .data(rx_char), .frame_err(rx_fe), .par_err(rx_pe)
  );

  sl_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(wr_ctl && bus_wdata[1]),
    .push(rx_done && !rx_full), .din(rx_char), .pop(rd_rx),
    .dout(rx_dout), .count(rx_count), .empty(rx_empty), .full(rx_full)
  );

  // sticky error flags, interrupt enable, interrupt edge detect
  logic ovr_q, ovr_n, fe_q, fe_n, pe_q, pe_n;
  logic ie_q, ie_n, irq_q, irq_n;
  logic rxe_q, txe_q;

  always_comb begin
    ovr_n = (rd_stat ? 1'b0 : ovr_q) | (rx_done && rx_full);
    fe_n  = (rd_stat ? 1'b0 : fe_q)  | (rx_done && rx_fe);
    pe_n  = (rd_stat ? 1'b0 : pe_q)  | (rx_done && rx_pe);
    ie_n  = wr_ctl ? bus_wdata[4] : ie_q;
    irq_n = ie_q && ((rxe_q && !rx_empty) || (!txe_q && tx_empty));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ovr_q <= 1'b0;
      fe_q  <= 1'b0;
      pe_q  <= 1'b0;
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
      rxe_q <= 1'b1;
      txe_q <= 1'b1;
    end else begin
      div_q <= div_n;
      ovr_q <= ovr_n;
      fe_q  <= fe_n;
      pe_q  <= pe_n;
      ie_q  <= ie_n;
      irq_q <= irq_n;
      rxe_q <= rx_empty;
      txe_q <= tx_empty;
    end
  end

  assign irq = irq_q;

  // read mux
  logic [7:0] status;
  assign status = {pe_q, fe_q, ovr_q, ie_q, tx_full, tx_empty, rx_full, !rx_empty};

  always_comb begin
    case (bus_addr)
      SLOT_RXDATA: bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_dout};
      SLOT_STATUS: bus_rdata = {24'd0, status};
      default:     bus_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/sl_lite_checker.sv
`timescale 1ns/1ps
module sl_lite_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    addr,
  input logic          wr,
  input logic          rd,
  input logic          wd_txrst,
  input logic [31:0]   rdata,
  input logic          irq,
  input logic          ie,
  input logic          tx_line,
  input logic          tx_busy,
  input logic          tx_take,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count
);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ie));

  assert_status_ie_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 2'd2) |-> (rdata[4] == ie));

  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 2'd0 && rx_count == '0) |-> (rdata == 32'd0));

  assert_rx_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  assert_tx_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  assert_txrst_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3 && wd_txrst) |=> (tx_count == '0));

  assert_full_write_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CW'(DEPTH) && wr && addr == 2'd1 && !tx_take) |=> (tx_count == CW'(DEPTH)));

endmodule

bind serial_lite_ctrl sl_lite_checker #(.DEPTH(FIFO_DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
  .wd_txrst(bus_wdata[0]), .rdata(bus_rdata), .irq(irq), .ie(ie_q),
  .tx_line(tx_line), .tx_busy(tx_busy), .tx_take(tx_take),
  .rx_count(rx_count), .tx_count(tx_count)
);

// File: tb/serial_lite_ctrl_tb_top.sv
`timescale 1ns/1ps
module serial_lite_ctrl_tb_top;

  localparam int BIT = 32;   // 2 clocks per tick x 16 ticks
  localparam logic [7:0] S_RXV = 8'h01, S_RXF = 8'h02, S_TXE = 8'h04, S_TXF = 8'h08;
  localparam logic [7:0] S_IE  = 8'h10, S_OV  = 8'h20, S_FE  = 8'h40, S_PE  = 8'h80;

  logic        clk, rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_line, tx_line, irq;

  int n_vec, n_bad, irq_cnt, cap_n;
  bit finished, mon_en;
  logic [7:0] cap_d [64];
  logic       cap_p [64];
  logic       cap_s [64];

  serial_lite_ctrl #(
    .CLKS_PER_TICK(2), .DATA_BITS(8),
    .PARITY(serial_lite_pkg::PAR_EVEN), .FIFO_DEPTH(16)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_line(rx_line), .tx_line(tx_line), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (irq === 1'b1) irq_cnt++;

  function automatic logic even_par(input logic [7:0] v);
    int ones;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(v[i]);
    return logic'(ones % 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic hold_rx(input logic v, input int cycles);
    rx_line = v;
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  task automatic send_rx(input logic [7:0] v, input logic flip_par, input logic bad_stop);
    @(posedge clk); #1;
    hold_rx(1'b0, BIT);
    for (int i = 0; i < 8; i++) hold_rx(v[i], BIT);
    hold_rx(even_par(v) ^ flip_par, BIT);
    if (bad_stop) begin
      hold_rx(1'b0, 26);
      hold_rx(1'b1, 2 * BIT);
    end else begin
      hold_rx(1'b1, BIT);
    end
  endtask

  task automatic wait_frames(input int base, input int n);
    int t;
    t = 0;
    while ((cap_n - base) < n && t < 20 * BIT * (n + 1)) begin
      @(negedge clk);
      t++;
    end
  endtask

  // background decoder of the transmit line
  initial begin
    logic [7:0] d;
    logic p, s;
    wait (mon_en);
    forever begin
      @(negedge tx_line);
      repeat (BIT / 2) @(negedge clk);
      d = '0;
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(negedge clk);
        d[i] = tx_line;
      end
      repeat (BIT) @(negedge clk);
      p = tx_line;
      repeat (BIT) @(negedge clk);
      s = tx_line;
      cap_d[cap_n % 64] = d;
      cap_p[cap_n % 64] = (p == even_par(d));
      cap_s[cap_n % 64] = s;
      cap_n++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  v;
    int base;
    n_vec = 0; n_bad = 0; irq_cnt = 0; cap_n = 0;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; rx_line = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    mon_en = 1'b1;

    // R1 reset state
    bus_read(2'd2, r);      chk("R1 status after reset", r, {24'd0, S_TXE});
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 tx line idle", {31'd0, tx_line}, 32'd1);
    bus_read(2'd0, r);      chk("R5 empty read after reset", r, 32'd0);

    // R2 receive sweep
    for (int i = 0; i < 128; i++) begin
      v = 8'((i * 73 + 11) & 255);
      send_rx(v, 1'b0, 1'b0);
      bus_read(2'd2, r);    chk("R2 rx valid flag", r, {24'd0, S_RXV | S_TXE});
      bus_read(2'd0, r);    chk("R2 rx data", r, {24'd0, v});
      bus_read(2'd2, r);    chk("R5 status after pop", r, {24'd0, S_TXE});
    end

    // R3 transmit sweep
    for (int i = 0; i < 64; i++) begin
      v = 8'((i * 151 + 3) & 255);
      base = cap_n;
      bus_write(2'd1, {24'hABCDEF, v});
      wait_frames(base, 1);
      chk("R3 frame count", 32'(cap_n - base), 32'd1);
      chk("R3 tx data", {24'd0, cap_d[base % 64]}, {24'd0, v});
      chk("R3 tx parity", {31'd0, cap_p[base % 64]}, 32'd1);
      chk("R3 tx stop", {31'd0, cap_s[base % 64]}, 32'd1);
    end

    // R8 parity error
    send_rx(8'h5A, 1'b1, 1'b0);
    bus_read(2'd2, r);      chk("R8 parity flag", r, {24'd0, S_PE | S_RXV | S_TXE});
    bus_read(2'd2, r);      chk("R8 parity flag cleared", r, {24'd0, S_RXV | S_TXE});
    bus_read(2'd0, r);      chk("R8 parity char stored", r, 32'h5A);

    // R8 framing error with short low stop
    send_rx(8'h3C, 1'b0, 1'b1);
    bus_read(2'd2, r);      chk("R8 framing flag", r, {24'd0, S_FE | S_RXV | S_TXE});
    bus_read(2'd2, r);      chk("R8 framing flag cleared", r, {24'd0, S_RXV | S_TXE});
    bus_read(2'd0, r);      chk("R8 framing char stored", r, 32'h3C);
    bus_read(2'd2, r);      chk("R8 no false start char", r, {24'd0, S_TXE});

    // R4 / R7 receive depth and overrun
    for (int i = 0; i < 16; i++) send_rx(8'(8'h80 + i), 1'b0, 1'b0);
    bus_read(2'd2, r);      chk("R4 rx full flag", r, {24'd0, S_RXF | S_RXV | S_TXE});
    send_rx(8'hEE, 1'b0, 1'b0);
    bus_read(2'd2, r);      chk("R7 overrun flag", r, {24'd0, S_OV | S_RXF | S_RXV | S_TXE});
    bus_read(2'd2, r);      chk("R7 overrun cleared", r, {24'd0, S_RXF | S_RXV | S_TXE});
    for (int i = 0; i < 16; i++) begin
      bus_read(2'd0, r);    chk("R4 rx order", r, 32'(8'h80 + i));
    end
    bus_read(2'd2, r);      chk("R7 dropped char absent", r, {24'd0, S_TXE});
    bus_read(2'd0, r);      chk("R5 empty read zero", r, 32'd0);
    bus_read(2'd2, r);      chk("R5 empty read no change", r, {24'd0, S_TXE});

    // R4 / R6 transmit depth and dropped write
    base = cap_n;
    for (int i = 0; i < 18; i++) bus_write(2'd1, 32'(8'h10 + i));
    bus_read(2'd2, r);      chk("R4 tx full flag", r, {24'd0, S_TXF});
    wait_frames(base, 17);
    repeat (3 * BIT) @(negedge clk);
    chk("R6 frames sent", 32'(cap_n - base), 32'd17);
    for (int i = 0; i < 17; i++)
      chk("R4 tx order", {24'd0, cap_d[(base + i) % 64]}, 32'(8'h10 + i));

    // R9 transmit queue clear
    base = cap_n;
    for (int i = 0; i < 5; i++) bus_write(2'd1, 32'(8'h40 + i));
    bus_write(2'd3, 32'h01);
    bus_read(2'd2, r);      chk("R9 tx empty after clear", r, {24'd0, S_TXE});
    repeat (15 * BIT) @(negedge clk);
    chk("R9 only in-flight char", 32'(cap_n - base), 32'd1);
    chk("R9 in-flight data", {24'd0, cap_d[base % 64]}, 32'h40);

    // R9 receive queue clear
    send_rx(8'h11, 1'b0, 1'b0);
    send_rx(8'h22, 1'b0, 1'b0);
    bus_write(2'd3, 32'h02);
    bus_read(2'd2, r);      chk("R9 rx cleared", r, {24'd0, S_TXE});
    bus_read(2'd0, r);      chk("R9 rx read after clear", r, 32'd0);

    // R10 interrupt
    bus_write(2'd3, 32'h10);
    bus_read(2'd2, r);      chk("R10 enable in status", r, {24'd0, S_IE | S_TXE});
    irq_cnt = 0;
    base = cap_n;
    bus_write(2'd1, 32'h77);
    wait_frames(base, 1);
    chk("R10 tx empty pulse", 32'(irq_cnt), 32'd1);
    irq_cnt = 0;
    send_rx(8'h21, 1'b0, 1'b0);
    chk("R10 rx pulse", 32'(irq_cnt), 32'd1);
    bus_read(2'd0, r);      chk("R10 rx data", r, 32'h21);
    repeat (4) @(negedge clk);
    chk("R10 no pulse on drain", 32'(irq_cnt), 32'd1);
    bus_write(2'd3, 32'h00);
    bus_read(2'd2, r);      chk("R10 disabled in status", r, {24'd0, S_TXE});
    irq_cnt = 0;
    base = cap_n;
    bus_write(2'd1, 32'h66);
    send_rx(8'h33, 1'b0, 1'b0);
    wait_frames(base, 1);
    chk("R10 no pulse when disabled", 32'(irq_cnt), 32'd0);
    bus_read(2'd0, r);      chk("R10 rx data when disabled", r, 32'h33);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule